// File: doc/BRIEF.md
# Block-Ack Transmit Window Tracker

This block follows one aggregation queue whose frames are acknowledged in blocks. It keeps a window of at most 64 consecutive ring entries that begins at the read pointer. For every entry in the window it holds two flags: whether the frame has gone out and whether the receiver has acknowledged it. New frames are handed downstream from the next-to-send pointer while the queue holds data and the window has room.

Block-ack reports arrive as a start sequence number and a 64-bit bitmap. A set bit marks the matching frame as acknowledged. A clear bit on a frame that is not yet acknowledged sends that frame back for retransmission. Because frames can complete out of order, the read pointer moves forward only across an unbroken run of acknowledged entries. Retransmissions take priority over new frames. Issue comes in bursts of at most a configured number of frames.

Top module: `ba_window_tracker`

## Requirements
- R1: After reset the read pointer and the next-to-send pointer are both 0 and no frame is offered.
- R2: When the queue is non-empty (next-to-send differs from `wr_ptr_i`) and no retransmission is pending, the offered index is the next-to-send pointer with `issue_retry_o`=0. Each accepted offer (`issue_valid_o` and `issue_ready_i` high on the same edge) advances that pointer by one, wrapping modulo 256.
- R3: The number of outstanding frames (next-to-send minus read pointer, modulo 256) never exceeds the effective window, which is `win_size_i` or 64, whichever is smaller.
- R4: `wsl_o` is 1 exactly when the outstanding count is below the effective window and the queue is non-empty.
- R5: Bitmap bit i of a report refers to ring index (`ba_ssn_i` + i) mod 256. For an outstanding frame, a set bit marks it acknowledged, and a clear bit on a frame not yet acknowledged marks it for retransmission.
- R6: Report bits whose index lies outside the outstanding range [read pointer, next-to-send) change nothing.
- R7: On the clock edge that takes a report, the read pointer moves past the contiguous run of acknowledged frames that starts at it, and stops at the first unacknowledged frame. It does not move otherwise.
- R8: A frame marked for retransmission is offered before any new frame, oldest first, with `issue_retry_o`=1. Offering it does not move the next-to-send pointer.
- R9: After `frame_limit_i` consecutive accepted offers, the block offers nothing for one cycle. Any cycle without an accepted offer restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| win_size_i | input | 7 | Configured window size (values above 64 act as 64) |
| frame_limit_i | input | 7 | Maximum frames per burst |
| wr_ptr_i | input | 8 | Queue write pointer (one past the last filled entry) |
| issue_ready_i | input | 1 | Downstream accepts the offered frame |
| issue_valid_o | output | 1 | A frame is offered |
| issue_idx_o | output | 8 | Ring index of the offered frame |
| issue_retry_o | output | 1 | Offered frame is a retransmission |
| wsl_o | output | 1 | Window has room and the queue has a frame for it |
| ba_valid_i | input | 1 | Block-ack report present this cycle |
| ba_ssn_i | input | 8 | Report start index |
| ba_bitmap_i | input | 64 | Report acknowledgement bitmap |
| rd_ptr_o | output | 8 | Read pointer (first frame of the window) |
| nxt_ptr_o | output | 8 | Next-to-send pointer |

## Verification
The bench sends a report that acknowledges frames on both sides of one lost frame. A tracker that slides over the whole acknowledged set, instead of stopping at the hole, would skip the retransmission, and a tracker that ignores priority would offer a new frame ahead of the lost one. It also sends stale reports whose indices alias the live window modulo 64. A design that indexed the slots without checking the window would then acknowledge or requeue live frames. Long runs cross the 256 wrap-around with `win_size_i` above 64, so a missing clamp or a pointer compared without wrap shows up as too many frames in flight or a stuck pointer. Burst sweeps check that the idle cycle lands after exactly `frame_limit_i` frames.

// File: rtl/bawt_pkg.sv
package bawt_pkg;
    typedef enum logic [1:0] {
        ISS_IDLE  = 2'd0,
        ISS_NEW   = 2'd1,
        ISS_RETRY = 2'd2
    } iss_kind_t;
endpackage

// File: rtl/bawt_first_set.sv
module bawt_first_set #(
    parameter int W  = 64,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          found_o,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        found_o = |vec_i;
        idx_o   = '0;
        for (int k = W - 1; k >= 0; k--) begin
            if (vec_i[k]) idx_o = IW'(k);
        end
    end

    // oldest-first retransmission pick (R8)
    always_comb begin
        if (found_o) begin
            assert_pick_valid_R8: assert (vec_i[idx_o]);
        end
    end
endmodule

// File: rtl/bawt_burst_gate.sv
module bawt_burst_gate #(
    parameter int CFG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fire_i,
    input  logic [CFG_W-1:0] limit_i,
    output logic             gap_o
);
    logic [CFG_W-1:0] cnt_d, cnt_q;

    always_comb begin
        gap_o = (cnt_q == limit_i);
        cnt_d = fire_i ? cnt_q + 1'b1 : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/ba_window_tracker.sv
module ba_window_tracker #(
    parameter int IDX_W   = 8,
    parameter int WIN_MAX = 64,
    parameter int CFG_W   = 7
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CFG_W-1:0]   win_size_i,
    input  logic [CFG_W-1:0]   frame_limit_i,
    input  logic [IDX_W-1:0]   wr_ptr_i,
    input  logic               issue_ready_i,
    output logic               issue_valid_o,
    output logic [IDX_W-1:0]   issue_idx_o,
    output logic               issue_retry_o,
    output logic               wsl_o,
    input  logic               ba_valid_i,
    input  logic [IDX_W-1:0]   ba_ssn_i,
    input  logic [WIN_MAX-1:0] ba_bitmap_i,
    output logic [IDX_W-1:0]   rd_ptr_o,
    output logic [IDX_W-1:0]   nxt_ptr_o
);
    import bawt_pkg::*;

    localparam int SLOT_W = $clog2(WIN_MAX);

    typedef struct packed {
        logic [IDX_W-1:0]   rd;
        logic [IDX_W-1:0]   nxt;
        logic [WIN_MAX-1:0] sent;
        logic [WIN_MAX-1:0] acked;
    } st_t;

    st_t st_d, st_q;

    logic [IDX_W-1:0]   outst;
    logic [IDX_W-1:0]   win_eff;
    logic               q_nonempty;
    logic [WIN_MAX-1:0] retry_vec;
    logic               retry_found;
    logic [SLOT_W-1:0]  retry_off;
    logic               gap;
    logic               fire;
    iss_kind_t          kind;
    logic [IDX_W-1:0]   b_idx, b_off, r_idx, run;
    logic               stop;

    assign outst      = st_q.nxt - st_q.rd;
    assign win_eff    = (int'(win_size_i) > WIN_MAX) ? IDX_W'(WIN_MAX) : IDX_W'(win_size_i);
    assign q_nonempty = (st_q.nxt != wr_ptr_i);
    assign wsl_o      = (outst < win_eff) && q_nonempty;

    // window view rotated so that bit 0 is the read pointer
    for (genvar j = 0; j < WIN_MAX; j++) begin : g_rot
        logic [IDX_W-1:0] w_idx;
        assign w_idx        = st_q.rd + IDX_W'(j);
        assign retry_vec[j] = (IDX_W'(j) < outst)
                            && !st_q.sent[w_idx[SLOT_W-1:0]]
                            && !st_q.acked[w_idx[SLOT_W-1:0]];
    end

    bawt_first_set #(.W(WIN_MAX), .IW(SLOT_W)) u_retry_pick (
        .vec_i   (retry_vec),
        .found_o (retry_found),
        .idx_o   (retry_off)
    );

    bawt_burst_gate #(.CFG_W(CFG_W)) u_burst (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire_i  (fire),
        .limit_i (frame_limit_i),
        .gap_o   (gap)
    );

    always_comb begin
        if (gap)              kind = ISS_IDLE;
        else if (retry_found) kind = ISS_RETRY;
        else if (wsl_o)       kind = ISS_NEW;
        else                  kind = ISS_IDLE;
    end

    assign issue_valid_o = (kind != ISS_IDLE);
    assign issue_retry_o = (kind == ISS_RETRY);
    assign issue_idx_o   = (kind == ISS_RETRY) ? st_q.rd + IDX_W'(retry_off) : st_q.nxt;
    assign fire          = issue_valid_o && issue_ready_i;
    assign rd_ptr_o      = st_q.rd;
    assign nxt_ptr_o     = st_q.nxt;

    always_comb begin
        st_d  = st_q;
        b_idx = '0;
        b_off = '0;
        r_idx = '0;
        run   = '0;
        stop  = 1'b0;
        // block-ack report: only outstanding entries are touched
        for (int i = 0; i < WIN_MAX; i++) begin
            b_idx = ba_ssn_i + IDX_W'(i);
            b_off = b_idx - st_q.rd;
            if (ba_valid_i && (b_off < outst)) begin
                if (ba_bitmap_i[i])
                    st_d.acked[b_idx[SLOT_W-1:0]] = 1'b1;
                else if (!st_q.acked[b_idx[SLOT_W-1:0]])
                    st_d.sent[b_idx[SLOT_W-1:0]] = 1'b0;
            end
        end
        // accepted offer
        if (fire) begin
            st_d.sent[issue_idx_o[SLOT_W-1:0]] = 1'b1;
            if (kind == ISS_NEW) begin
                st_d.acked[issue_idx_o[SLOT_W-1:0]] = 1'b0;
                st_d.nxt = st_q.nxt + 1'b1;
            end
        end
        // slide over the contiguous acknowledged run
        for (int j = 0; j < WIN_MAX; j++) begin
            r_idx = st_q.rd + IDX_W'(j);
            if (!stop) begin
                if ((IDX_W'(j) < outst) && st_d.acked[r_idx[SLOT_W-1:0]]) run = run + 1'b1;
                else stop = 1'b1;
            end
        end
        st_d.rd = st_q.rd + run;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // burst-length monitor kept apart from the gate counter
    logic [CFG_W:0] consec_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    consec_q <= '0;
        else if (fire) consec_q <= consec_q + 1'b1;
        else           consec_q <= '0;
    end

    assert_burst_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        consec_q <= {1'b0, frame_limit_i});

    assert_window_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        outst <= IDX_W'(WIN_MAX));

    assert_new_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !issue_retry_o) |=> (st_q.nxt == $past(st_q.nxt) + 1'b1));

    assert_hold_nxt_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!fire || issue_retry_o) |=> $stable(st_q.nxt));

    assert_slide_on_report_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ba_valid_i |=> $stable(st_q.rd));
endmodule

// File: tb/tb_ba_window_tracker.sv
module tb_ba_window_tracker;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [6:0]  win_size_i, frame_limit_i;
    logic [7:0]  wr_ptr_i;
    logic        issue_ready_i;
    logic        issue_valid_o;
    logic [7:0]  issue_idx_o;
    logic        issue_retry_o;
    logic        wsl_o;
    logic        ba_valid_i;
    logic [7:0]  ba_ssn_i;
    logic [63:0] ba_bitmap_i;
    logic [7:0]  rd_ptr_o, nxt_ptr_o;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #5 clk = ~clk;

    ba_window_tracker dut (
        .clk(clk), .rst_n(rst_n), .win_size_i(win_size_i), .frame_limit_i(frame_limit_i),
        .wr_ptr_i(wr_ptr_i), .issue_ready_i(issue_ready_i), .issue_valid_o(issue_valid_o),
        .issue_idx_o(issue_idx_o), .issue_retry_o(issue_retry_o), .wsl_o(wsl_o),
        .ba_valid_i(ba_valid_i), .ba_ssn_i(ba_ssn_i), .ba_bitmap_i(ba_bitmap_i),
        .rd_ptr_o(rd_ptr_o), .nxt_ptr_o(nxt_ptr_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    task automatic report(input logic [7:0] ssn, input logic [63:0] bm);
        ba_valid_i = 1'b1; ba_ssn_i = ssn; ba_bitmap_i = bm;
        tick();
        ba_valid_i = 1'b0; ba_bitmap_i = '0;
        #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=0 exp=1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int issued;
        int start;
        rst_n = 1'b0; win_size_i = 7'd64; frame_limit_i = 7'd10; wr_ptr_i = '0;
        issue_ready_i = 1'b0; ba_valid_i = 1'b0; ba_ssn_i = '0; ba_bitmap_i = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        // R1 reset state
        chk("R1 rd", rd_ptr_o, 0);
        chk("R1 nxt", nxt_ptr_o, 0);
        chk("R1 valid", issue_valid_o, 0);

        // R2 in-order new frames
        wr_ptr_i = 8'd5; issue_ready_i = 1'b1; #1;
        for (int k = 0; k < 5; k++) begin
            chk("R2 valid", issue_valid_o, 1);
            chk("R2 idx", issue_idx_o, k);
            chk("R2 retry", issue_retry_o, 0);
            tick(); #1;
        end
        chk("R2 empty no offer", issue_valid_o, 0);
        chk("R2 nxt", nxt_ptr_o, 5);
        issue_ready_i = 1'b0;
        report(8'd0, 64'h1F);
        chk("R7 full run", rd_ptr_o, 5);

        // R9 burst gaps with limit 4
        frame_limit_i = 7'd4; wr_ptr_i = 8'd17; issue_ready_i = 1'b1; #1;
        for (int c = 0; c < 15; c++) begin
            if (c % 5 == 4) chk("R9 gap", issue_valid_o, 0);
            else begin
                chk("R9 valid", issue_valid_o, 1);
                chk("R9 idx", issue_idx_o, 5 + c - c / 5);
            end
            tick(); #1;
        end
        chk("R9 nxt", nxt_ptr_o, 17);
        issue_ready_i = 1'b0; frame_limit_i = 7'd10;
        report(8'd5, 64'hFFF);
        chk("R7 rd", rd_ptr_o, 17);

        // R3/R4 window of 8
        win_size_i = 7'd8; wr_ptr_i = 8'd37; #1;
        chk("R4 wsl room", wsl_o, 1);
        issue_ready_i = 1'b1; #1;
        for (int k = 0; k < 8; k++) begin
            chk("R3 idx", issue_idx_o, 17 + k);
            tick(); #1;
        end
        chk("R3 full no offer", issue_valid_o, 0);
        chk("R4 wsl full", wsl_o, 0);
        chk("R3 nxt", nxt_ptr_o, 25);

        // R5/R7/R8 out-of-order ack with one hole at 19
        issue_ready_i = 1'b0;
        report(8'd17, 64'hFB);
        chk("R7 stop at hole", rd_ptr_o, 19);
        chk("R4 wsl after slide", wsl_o, 1);
        issue_ready_i = 1'b1; #1;
        chk("R8 retry valid", issue_valid_o, 1);
        chk("R8 retry idx", issue_idx_o, 19);
        chk("R8 retry flag", issue_retry_o, 1);
        tick(); #1;
        chk("R8 nxt held", nxt_ptr_o, 25);
        chk("R2 new after retry", issue_idx_o, 25);
        chk("R2 new flag", issue_retry_o, 0);
        tick(); #1;
        chk("R2 new idx", issue_idx_o, 26);
        tick(); #1;
        chk("R3 full again", issue_valid_o, 0);

        // R6 stale reports aliasing the live window modulo 64
        report(8'd200, '1);
        chk("R6 stale ack ignored", rd_ptr_o, 19);
        chk("R6 no offer", issue_valid_o, 0);
        report(8'd200, '0);
        chk("R6 stale nack ignored", issue_valid_o, 0);
        issue_ready_i = 1'b0;
        report(8'd19, 64'hC1);
        chk("R5 bit mapping slide", rd_ptr_o, 27);

        // R3 clamp above 64, then wrap-around
        win_size_i = 7'd100; frame_limit_i = 7'd127; wr_ptr_i = 8'd97;
        issue_ready_i = 1'b1; #1;
        for (int k = 0; k < 64; k++) begin
            chk("R3 clamp idx", issue_idx_o, 27 + k);
            tick(); #1;
        end
        chk("R3 clamp stop", issue_valid_o, 0);
        chk("R4 wsl clamp", wsl_o, 0);
        chk("R3 clamp nxt", nxt_ptr_o, 91);
        issue_ready_i = 1'b0;
        report(8'd27, '1);
        chk("R7 rd 91", rd_ptr_o, 91);

        wr_ptr_i = 8'd35; issued = 0; start = 91;
        for (int b = 0; b < 6 && issued < 200; b++) begin
            issue_ready_i = 1'b1; #1;
            for (int c = 0; c < 70; c++) begin
                if (!issue_valid_o) break;
                chk("R2 wrap idx", issue_idx_o, (91 + issued) % 256);
                issued++;
                tick(); #1;
            end
            issue_ready_i = 1'b0;
            report(8'(start), '1);
            start = (91 + issued) % 256;
        end
        chk("R2 wrap count", issued, 200);
        chk("R7 wrap rd", rd_ptr_o, 35);
        chk("R2 wrap nxt", nxt_ptr_o, 35);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule